// File: doc/BRIEF.md
# Bit-Plane Crosspoint Configuration Loader

This block rewrites the complete input-selection set of a 16-output crosspoint switch in one short burst. The selections are held in an external configuration memory as four 16-bit words, each word holding one bit plane: word k carries bit k of the 4-bit input selection of every output port. A rising edge on the load request starts a burst. The loader then drives the memory address itself, one location per clock, and captures the returned words. Once the last plane is in, it either signals that it is ready or, when automatic transfer is enabled, first fires a one-clock configuration strobe toward the switch core and then signals ready.

The assembled selection set is presented to the core continuously. Planes are written one at a time into the selection registers. An output whose selection does not change sees identical bits in every plane, so its path is never disturbed during a reload. The memory address pins can be released by an active-low enable; the release is modelled as an output-enable flag.

Top module: `xpt_plane_loader`

## Requirements
- R1: In reset, ready is low, the configuration strobe is low, the memory address is 0 and every port selection is 0 (all outputs take input 0).
- R2: A start is a clock edge where the load input is high and was low at the previous edge. After a start edge, ready is low and the memory address is 0.
- R3: After the start edge (E0), the memory address reads 1, 2 and 3 after edges E1, E2 and E3, advancing by one per clock, and then holds at 3.
- R4: The address output-enable is the inverse of the active-low address enable input, with no clock delay.
- R5: The word on the data input at edge E(k+2) is plane k, so memory returns the word for address k one clock after the address is driven. Bit n of plane k becomes bit k of the selection of port n, which is output on bits [4n+3:4n] of the selection bus. After E5 the bus holds the complete new set.
- R6: With automatic transfer off at E5, ready rises after E5 and the configuration strobe stays low.
- R7: With automatic transfer on at E5, the configuration strobe is high for exactly the one cycle after E5 and ready rises after E6.
- R8: The active-low external configuration input, when sampled low, clears ready. A clear in the same cycle as the completion of a burst takes precedence over setting ready, and ready stays low until the next burst completes.
- R9: A start edge that arrives during a burst restarts it from plane 0 and address 0. The timing of R3 to R7 is then counted from the new start edge, and the result contains only words fetched after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load request; a rising edge starts a burst |
| auto_cfg_i | input | 1 | Enable the automatic configuration strobe at the end of a burst |
| addr_en_n_i | input | 1 | Active-low enable for the memory address pins |
| cfg_n_i | input | 1 | Active-low external configuration strobe; clears ready |
| word_i | input | NPORTS | Bit-plane word returned by the configuration memory |
| mem_addr_o | output | $clog2(PLANES) | Configuration memory address |
| mem_addr_oe_o | output | 1 | Address output-enable |
| ready_o | output | 1 | Burst complete and configuration in place |
| cfg_pulse_o | output | 1 | One-clock internal configuration strobe to the core |
| sel_o | output | NPORTS*PLANES | Selection of every output port, port n at bits [PLANES*n+PLANES-1:PLANES*n] |

## Verification
The bench builds the loader with its default values, 16 ports and 4 planes. At this size the full 64-bit selection bus and all four address values can be compared against selections rebuilt in the bench from the plane words. Bit patterns such as checkerboards, a single high bit at either end of a word, all ones and all zeros show any transposition or plane-order error on a particular port. The four-plane burst also places the completion edge, the strobe cycle, a restart in the middle of a burst and a clear that collides with completion at fixed cycles, where each is checked.

// File: rtl/xpt_plane_loader.sv
module xpt_plane_loader #(
  parameter int NPORTS = 16,
  parameter int PLANES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       auto_cfg_i,
  input  logic                       addr_en_n_i,
  input  logic                       cfg_n_i,
  input  logic [NPORTS-1:0]          word_i,
  output logic [$clog2(PLANES)-1:0]  mem_addr_o,
  output logic                       mem_addr_oe_o,
  output logic                       ready_o,
  output logic                       cfg_pulse_o,
  output logic [NPORTS*PLANES-1:0]   sel_o
);
  localparam int AW = $clog2(PLANES);
  localparam int CW = $clog2(PLANES + 2);

  logic          load_q;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic          ready_q;
  logic          pulse_q;
  logic [AW-1:0] pidx;

  wire start   = load_i & ~load_q;
  wire last    = busy && (cnt == CW'(PLANES));
  wire capture = busy && !start && (cnt != '0);

  assign pidx          = AW'(cnt - 1'b1);
  assign mem_addr_o    = addr;
  assign mem_addr_oe_o = ~addr_en_n_i;
  assign ready_o       = ready_q;
  assign cfg_pulse_o   = pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      addr    <= '0;
      pulse_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      load_q  <= load_i;
      pulse_q <= !start && last && auto_cfg_i;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        addr <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt < CW'(PLANES - 1)) addr <= addr + 1'b1;
        if (last) busy <= 1'b0;
      end
      if (start || !cfg_n_i)            ready_q <= 1'b0;
      else if (last && !auto_cfg_i)     ready_q <= 1'b1;
      else if (pulse_q)                 ready_q <= 1'b1;
    end
  end

  for (genvar n = 0; n < NPORTS; n++) begin : g_port
    logic [PLANES-1:0] sel_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       sel_q <= '0;
      else if (capture) sel_q[pidx] <= word_i[n];
    end
    assign sel_o[n*PLANES +: PLANES] = sel_q;
  end

  assert_start_clears_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!ready_o && mem_addr_o == '0));

  assert_addr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && cnt < CW'(PLANES - 1)) |=> mem_addr_o == AW'($past(mem_addr_o) + 1'b1));

  assert_pulse_one_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pulse_o |=> !cfg_pulse_o);

  assert_pulse_then_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pulse_o && !start && cfg_n_i) |=> ready_o);

  assert_no_pulse_when_manual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start && !auto_cfg_i) |=> !cfg_pulse_o);

  assert_ext_cfg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n_i |=> !ready_o);

  always_comb assert_oe_inverse_R4: assert (mem_addr_oe_o == !addr_en_n_i);
endmodule

// File: tb/xpt_plane_loader_tb.sv
module xpt_plane_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic        auto_cfg_i = 1'b0;
  logic        addr_en_n_i = 1'b0;
  logic        cfg_n_i = 1'b1;
  logic [15:0] word_i = '0;
  logic [1:0]  mem_addr_o;
  logic        mem_addr_oe_o;
  logic        ready_o;
  logic        cfg_pulse_o;
  logic [63:0] sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mem [4];
  logic [1:0]  prev_addr = '0;

  xpt_plane_loader u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .auto_cfg_i(auto_cfg_i),
    .addr_en_n_i(addr_en_n_i), .cfg_n_i(cfg_n_i), .word_i(word_i),
    .mem_addr_o(mem_addr_o), .mem_addr_oe_o(mem_addr_oe_o), .ready_o(ready_o),
    .cfg_pulse_o(cfg_pulse_o), .sel_o(sel_o)
  );

  always #2 clk = ~clk;

  // memory model: word for an address appears one clock after it is driven
  always @(negedge clk) begin
    word_i    = mem[prev_addr];
    prev_addr = mem_addr_o;
  end

  localparam logic [64:0] VEC [6] = '{
    {1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000},
    {1'b1, 16'hA5A5, 16'h3C3C, 16'h0F0F, 16'hFF00},
    {1'b0, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0},
    {1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h0001, 16'h8000, 16'h0001, 16'h8000},
    {1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
  };

  function automatic logic [63:0] exp_sel();
    logic [63:0] r = '0;
    for (int n = 0; n < 16; n++)
      for (int k = 0; k < 4; k++)
        r[n*4+k] = mem[k][n];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_burst();
    @(negedge clk) load_i = 1'b1;
  endtask

  // waits from the negedge before E0 through the negedge after E6
  task automatic run_burst(input bit a);
    logic [63:0] e;
    auto_cfg_i = a;
    start_burst();
    @(negedge clk);
    chk("R2 ready low after start", 64'(ready_o), 64'd0);
    chk("R3 address 0", 64'(mem_addr_o), 64'd0);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk("R3 address step", 64'(mem_addr_o), 64'(k));
    end
    @(negedge clk);
    chk("R3 address holds", 64'(mem_addr_o), 64'd3);
    @(negedge clk);
    e = exp_sel();
    chk("R5 selections", sel_o, e);
    if (!a) begin
      chk("R6 ready after E5", 64'(ready_o), 64'd1);
      chk("R6 no strobe", 64'(cfg_pulse_o), 64'd0);
    end else begin
      chk("R7 ready waits for strobe", 64'(ready_o), 64'd0);
      chk("R7 strobe after E5", 64'(cfg_pulse_o), 64'd1);
    end
    @(negedge clk);
    chk(a ? "R7 ready after strobe" : "R6 ready stays", 64'(ready_o), 64'd1);
    chk(a ? "R7 strobe one wide" : "R6 no strobe", 64'(cfg_pulse_o), 64'd0);
    load_i = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(ready_o), 64'd0);
    chk("R1 reset strobe", 64'(cfg_pulse_o), 64'd0);
    chk("R1 reset address", 64'(mem_addr_o), 64'd0);
    chk("R1 reset selections", sel_o, 64'd0);
    rst_n = 1'b1;

    addr_en_n_i = 1'b1;
    #1 chk("R4 address released", 64'(mem_addr_oe_o), 64'd0);
    addr_en_n_i = 1'b0;
    #1 chk("R4 address driven", 64'(mem_addr_oe_o), 64'd1);

    for (int v = 0; v < 6; v++) begin
      mem[0] = VEC[v][63:48];
      mem[1] = VEC[v][47:32];
      mem[2] = VEC[v][31:16];
      mem[3] = VEC[v][15:0];
      run_burst(VEC[v][64]);
    end

    // R8: external strobe clears ready, which stays low
    @(negedge clk) cfg_n_i = 1'b0;
    @(negedge clk) cfg_n_i = 1'b1;
    chk("R8 external strobe clears ready", 64'(ready_o), 64'd0);
    @(negedge clk);
    chk("R8 ready stays low", 64'(ready_o), 64'd0);

    // R8: clear collides with completion (manual mode)
    mem[0] = 16'hF0F0; mem[1] = 16'h00FF; mem[2] = 16'hCCCC; mem[3] = 16'h1111;
    auto_cfg_i = 1'b0;
    start_burst();
    repeat (5) @(negedge clk);
    cfg_n_i = 1'b0;
    @(negedge clk) cfg_n_i = 1'b1;
    chk("R8 clear beats completion", 64'(ready_o), 64'd0);
    chk("R5 selections under clear", sel_o, exp_sel());
    @(negedge clk);
    chk("R8 ready not re-set", 64'(ready_o), 64'd0);
    load_i = 1'b0;

    // R9: restart in the middle of a burst
    mem[0] = 16'hAAAA; mem[1] = 16'hAAAA; mem[2] = 16'hAAAA; mem[3] = 16'hAAAA;
    auto_cfg_i = 1'b0;
    start_burst();
    repeat (3) @(negedge clk);
    load_i = 1'b0;
    mem[0] = 16'h5555; mem[1] = 16'h3333; mem[2] = 16'h0F0F; mem[3] = 16'h00FF;
    @(negedge clk) load_i = 1'b1;
    @(negedge clk);
    chk("R9 restart address 0", 64'(mem_addr_o), 64'd0);
    chk("R9 restart ready low", 64'(ready_o), 64'd0);
    repeat (4) @(negedge clk);
    chk("R9 no early ready", 64'(ready_o), 64'd0);
    @(negedge clk);
    chk("R9 ready after restart", 64'(ready_o), 64'd1);
    chk("R9 selections from restart", sel_o, exp_sel());
    load_i = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule